// File: doc/BRIEF.md
# Sixteen-Bit Timer and Event Counter with Shared Prescaler

This block is a 16-bit up-counter that either counts ticks from an internal divided clock (timer use) or counts high-to-low transitions on an external event pin (counter use). Its clock is the oscillator clock. The internal tick comes from a prescaler whose select input is common to every timer instance in the system, so it enters as a port and not as a register field. A gate option makes counting depend on an external enable pin as well as the run bit.

A two-bit mode field chooses one of four arrangements: 16-bit with automatic reload from a reload register, 16-bit free-running, 8-bit with automatic reload from the upper count byte, and split operation as two independent 8-bit timers. Split operation is available only when the `SPLIT_EN` parameter is set. A small register port gives access to control, count, reload and flags. Overflow flags drive two interrupt lines, and an acknowledge input clears them.

Top module: `tmr_cnt_unit`

## Requirements
- R1: After reset the control, count, reload and flag registers all read 0, and both interrupt outputs are low.
- R2: `psc_sel` picks the internal tick rate: 2'b00 gives one tick per 4 clocks, 2'b01 one per 16, 2'b10 one per 64, and 2'b11 gives no ticks at all.
- R3: Control bit 0 (run) enables counting. With control bit 2 (gate) set, counting also needs `ext_en` high. With gate cleared, `ext_en` has no effect. With run cleared and no write, the count holds.
- R4: With control bit 1 set, the count source is falling edges on `ext_evt`, sampled every second clock. Each low and high level held for at least 4 clocks counts exactly once. With bit 1 cleared, the pin is ignored.
- R5: Mode 2'b00 (control bits 4:3): on a tick at count FFFFh, the count loads the reload register (address 2) and sets overflow flag 0.
- R6: Mode 2'b01: on a tick at count FFFFh, the count wraps to 0000h and sets overflow flag 0.
- R7: Mode 2'b10: the low byte counts. On a tick at low byte FFh, it loads the high byte and sets flag 0. The high byte does not change.
- R8: Mode 2'b11 with `SPLIT_EN`=1: the low byte counts and wraps under run, gate and source as usual, and sets flag 0. The high byte counts internal ticks while control bit 5 is set, wraps, and sets flag 1.
- R9: Flags (address 3, bit 0 and bit 1) drive `irq_lo` and `irq_hi`. A write to address 3 loads both flags. `irq_ack[0]` and `irq_ack[1]` clear them. A set from an overflow wins over a clear in the same cycle.
- R10: The count (address 1) can be read while it runs, and a software write loads it. The read data appears one clock after `rd_addr` is presented.
- R11: With `SPLIT_EN`=0, mode 2'b11 holds the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| psc_sel | input | 2 | Shared prescale select |
| ext_evt | input | 1 | External event pin, counted on falling edges |
| ext_en | input | 1 | External enable pin used when gate is set |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 count, 2 reload, 3 flags |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | CNT_W | Registered read data |
| irq_ack | input | 2 | Acknowledge pulses clearing flag 0 and flag 1 |
| irq_lo | output | 1 | Overflow interrupt for the main or low counter |
| irq_hi | output | 1 | Overflow interrupt for the split high byte |

## Verification
The assertions check on every cycle that the reserved prescale setting yields no tick, that ticks and detected edges never come on back-to-back cycles, that a stopped counter holds its value, that the high byte is untouched in 8-bit reload mode, and that overflow sets and acknowledges reach the interrupt lines one cycle later. Only the bench scenarios can show the actual division ratios, the effect of the gate pin, the exact number of counted edges, and the reload, wrap and split values after each kind of overflow. They also show that the variant without split operation freezes in mode 3.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_RLD16  = 2'b00,
    MD_FREE16 = 2'b01,
    MD_RLD8   = 2'b10,
    MD_SPLIT8 = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_COUNT  = 2'd1;
  localparam logic [1:0] REG_RELOAD = 2'd2;
  localparam logic [1:0] REG_FLAGS  = 2'd3;

  localparam logic [1:0] PSC_DIV4  = 2'b00;
  localparam logic [1:0] PSC_DIV16 = 2'b01;
  localparam logic [1:0] PSC_DIV64 = 2'b10;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_psc.sv
module tmr_psc #(
  parameter int DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  output logic       tick
);
  import tmr_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic             hit;
  logic             tick_q;

  always_comb begin
    unique case (sel)
      PSC_DIV4:  hit = &div_q[1:0];
      PSC_DIV16: hit = &div_q[3:0];
      PSC_DIV64: hit = &div_q[5:0];
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_q <= hit;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/tmr_evt_edge.sv
module tmr_evt_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  output logic fall
);
  logic phase_q;
  logic smp_q;
  logic fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      smp_q   <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      fall_q  <= 1'b0;
      if (phase_q) begin
        smp_q  <= pin_s;
        fall_q <= smp_q & ~pin_s;
      end
    end
  end

  assign fall = fall_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W    = 16,
  parameter bit SPLIT_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tmr_pkg::tmr_mode_e   mode,
  input  logic                 en_lo,
  input  logic                 tick_lo,
  input  logic                 en_hi,
  input  logic                 tick_hi,
  input  logic                 ld_en,
  input  logic [CNT_W-1:0]     ld_val,
  input  logic [CNT_W-1:0]     reload,
  output logic [CNT_W-1:0]     count,
  output logic                 ovf_lo,
  output logic                 ovf_hi
);
  import tmr_pkg::*;

  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic             ov_l, ov_h;
  logic             ovl_q, ovh_q;
  logic [HALF-1:0]  hi_step;
  logic             hi_wrap;
  logic             split_ok;
  logic             step;

  generate
    if (SPLIT_EN) begin : g_split
      always_comb begin
        hi_step = cnt_q[CNT_W-1:HALF];
        hi_wrap = 1'b0;
        if (en_hi && tick_hi) begin
          hi_step = cnt_q[CNT_W-1:HALF] + 1'b1;
          hi_wrap = &cnt_q[CNT_W-1:HALF];
        end
      end
      assign split_ok = 1'b1;
    end else begin : g_nosplit
      assign hi_step  = cnt_q[CNT_W-1:HALF];
      assign hi_wrap  = 1'b0;
      assign split_ok = 1'b0;
    end
  endgenerate

  assign step = en_lo & tick_lo;

  always_comb begin
    nxt  = cnt_q;
    ov_l = 1'b0;
    ov_h = 1'b0;
    unique case (mode)
      MD_RLD16: begin
        if (step) begin
          if (&cnt_q) begin
            nxt  = reload;
            ov_l = 1'b1;
          end else begin
            nxt = cnt_q + 1'b1;
          end
        end
      end
      MD_FREE16: begin
        if (step) begin
          nxt  = cnt_q + 1'b1;
          ov_l = &cnt_q;
        end
      end
      MD_RLD8: begin
        if (step) begin
          if (&cnt_q[HALF-1:0]) begin
            nxt[HALF-1:0] = cnt_q[CNT_W-1:HALF];
            ov_l          = 1'b1;
          end else begin
            nxt[HALF-1:0] = cnt_q[HALF-1:0] + 1'b1;
          end
        end
      end
      MD_SPLIT8: begin
        if (split_ok) begin
          if (step) begin
            nxt[HALF-1:0] = cnt_q[HALF-1:0] + 1'b1;
            ov_l          = &cnt_q[HALF-1:0];
          end
          nxt[CNT_W-1:HALF] = hi_step;
          ov_h              = hi_wrap;
        end
      end
      default: nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovl_q <= 1'b0;
      ovh_q <= 1'b0;
    end else if (ld_en) begin
      cnt_q <= ld_val;
      ovl_q <= 1'b0;
      ovh_q <= 1'b0;
    end else begin
      cnt_q <= nxt;
      ovl_q <= ov_l;
      ovh_q <= ov_h;
    end
  end

  assign count  = cnt_q;
  assign ovf_lo = ovl_q;
  assign ovf_hi = ovh_q;
endmodule

// File: rtl/tmr_cnt_unit.sv
module tmr_cnt_unit #(
  parameter int CNT_W    = 16,
  parameter int PSC_W    = 6,
  parameter int SYNC_W   = 2,
  parameter bit SPLIT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       psc_sel,
  input  logic             ext_evt,
  input  logic             ext_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [1:0]       irq_ack,
  output logic             irq_lo,
  output logic             irq_hi
);
  import tmr_pkg::*;

  localparam int CTRL_W = 6;

  logic       run_q, ct_q, gate_q, run_hi_q;
  tmr_mode_e  mode_q;
  logic [CNT_W-1:0] reload_q;
  logic [1:0] flag_q, flag_nxt;
  logic [CNT_W-1:0] rd_q;
  logic [CNT_W-1:0] cnt;

  logic psc_tick, evt_s, en_s, evt_tick;
  logic en_lo, tick_lo, ovf_lo, ovf_hi;
  logic wr_ctrl, wr_cnt, wr_rld, wr_flg;

  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == REG_COUNT);
  assign wr_rld  = wr_en && (wr_addr == REG_RELOAD);
  assign wr_flg  = wr_en && (wr_addr == REG_FLAGS);

  tmr_psc #(.DIV_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .sel(psc_sel), .tick(psc_tick)
  );

  tmr_sync #(.STAGES(SYNC_W)) u_sync_evt (
    .clk(clk), .rst(rst), .d(ext_evt), .q(evt_s)
  );

  tmr_sync #(.STAGES(SYNC_W)) u_sync_en (
    .clk(clk), .rst(rst), .d(ext_en), .q(en_s)
  );

  tmr_evt_edge u_edge (
    .clk(clk), .rst(rst), .pin_s(evt_s), .fall(evt_tick)
  );

  assign en_lo   = run_q & (~gate_q | en_s);
  assign tick_lo = ct_q ? evt_tick : psc_tick;

  tmr_core #(.CNT_W(CNT_W), .SPLIT_EN(SPLIT_EN)) u_core (
    .clk(clk), .rst(rst), .mode(mode_q),
    .en_lo(en_lo), .tick_lo(tick_lo),
    .en_hi(run_hi_q), .tick_hi(psc_tick),
    .ld_en(wr_cnt), .ld_val(wr_data), .reload(reload_q),
    .count(cnt), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      ct_q     <= 1'b0;
      gate_q   <= 1'b0;
      mode_q   <= MD_RLD16;
      run_hi_q <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q    <= wr_data[0];
        ct_q     <= wr_data[1];
        gate_q   <= wr_data[2];
        mode_q   <= tmr_mode_e'(wr_data[4:3]);
        run_hi_q <= wr_data[5];
      end
      if (wr_rld) reload_q <= wr_data;
    end
  end

  always_comb begin
    flag_nxt = flag_q;
    if (wr_flg) flag_nxt = wr_data[1:0];
    flag_nxt = flag_nxt & ~irq_ack;
    flag_nxt = flag_nxt | {ovf_hi, ovf_lo};
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      unique case (rd_addr)
        REG_CTRL:   rd_q <= CNT_W'({run_hi_q, mode_q, gate_q, ct_q, run_q});
        REG_COUNT:  rd_q <= cnt;
        REG_RELOAD: rd_q <= reload_q;
        default:    rd_q <= CNT_W'(flag_q);
      endcase
    end
  end

  assign rd_data = rd_q;
  assign irq_lo  = flag_q[0];
  assign irq_hi  = flag_q[1];

  logic [CTRL_W-1:0] unused_hi;
  assign unused_hi = wr_data[CTRL_W-1:0];
endmodule

// File: rtl/tmr_cnt_unit_chk.sv
module tmr_cnt_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       psc_sel,
  input logic             psc_tick,
  input logic             evt_tick,
  input logic [1:0]       mode,
  input logic             run,
  input logic             run_hi,
  input logic             wr_cnt,
  input logic [CNT_W-1:0] count,
  input logic             ovf_lo,
  input logic             ovf_hi,
  input logic [1:0]       irq_ack,
  input logic             irq_lo,
  input logic             irq_hi
);
  localparam int HALF = CNT_W / 2;

  // R2
  psc_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    (psc_sel == 2'b11) |=> !psc_tick);

  // R2
  psc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    psc_tick |=> !psc_tick);

  // R4
  evt_gap_chk: assert property (@(posedge clk) disable iff (rst)
    evt_tick |=> !evt_tick);

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !run_hi && !wr_cnt) |=> $stable(count));

  // R7
  rld8_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !wr_cnt) |=> $stable(count[CNT_W-1:HALF]));

  // R9
  ovf_lo_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_lo |=> irq_lo);

  // R9
  ovf_hi_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_hi |=> irq_hi);

  // R9
  ack_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[0] && !ovf_lo) |=> !irq_lo);

  // R9
  ack_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack[1] && !ovf_hi) |=> !irq_hi);
endmodule

bind tmr_cnt_unit tmr_cnt_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .psc_sel(psc_sel), .psc_tick(psc_tick),
  .evt_tick(evt_tick), .mode(mode_q), .run(run_q), .run_hi(run_hi_q),
  .wr_cnt(wr_cnt), .count(cnt), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi),
  .irq_ack(irq_ack), .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/sim_tmr_cnt_unit.sv
`timescale 1ns/1ps
module sim_tmr_cnt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  psc_sel = 2'b00;
  logic        ext_evt = 1'b1;
  logic        ext_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data, rd_data1;
  logic [1:0]  irq_ack = 2'b00;
  logic        irq_lo, irq_hi, irq_lo1, irq_hi1;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tmr_cnt_unit #(.SPLIT_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .psc_sel(psc_sel), .ext_evt(ext_evt), .ext_en(ext_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_ack(irq_ack), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  tmr_cnt_unit #(.SPLIT_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .psc_sel(psc_sel), .ext_evt(ext_evt), .ext_en(ext_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data1), .irq_ack(irq_ack), .irq_lo(irq_lo1), .irq_hi(irq_hi1)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic rd1(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data1;
  endtask

  // captures of the two reads lie exactly span clocks apart
  task automatic measure(input int span, output logic [15:0] diff);
    logic [15:0] c0, c1;
    rd(2'd1, c0);
    repeat (span - 2) @(negedge clk);
    rd(2'd1, c1);
    diff = c1 - c0;
  endtask

  task automatic wait_irq(input bit hi, input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ((hi ? irq_hi : irq_lo) === 1'b1) return;
    end
    chk(req, 16'h0, 16'h1);
  endtask

  task automatic stop_all();
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(2'd1, v); chk("R1 count", v, 16'h0);
    rd(2'd2, v); chk("R1 reload", v, 16'h0);
    rd(2'd3, v); chk("R1 flags", v, 16'h0);
    chk("R1 irq", {14'h0, irq_hi, irq_lo}, 16'h0);
  endtask

  task automatic t_presc();
    logic [15:0] d;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0009);
    psc_sel = 2'b00; repeat (70) @(negedge clk);
    measure(40, d);  chk("R2 div4", d, 16'd10);
    psc_sel = 2'b01; repeat (70) @(negedge clk);
    measure(160, d); chk("R2 div16", d, 16'd10);
    psc_sel = 2'b10; repeat (70) @(negedge clk);
    measure(640, d); chk("R2 div64 R10 live read", d, 16'd10);
    psc_sel = 2'b11; repeat (70) @(negedge clk);
    measure(200, d); chk("R2 reserved", d, 16'd0);
    stop_all();
  endtask

  task automatic t_gate();
    logic [15:0] d;
    psc_sel = 2'b00;
    ext_en = 1'b0;
    wr(2'd0, 16'h000D);
    repeat (10) @(negedge clk);
    measure(40, d); chk("R3 gate closed", d, 16'd0);
    ext_en = 1'b1;
    repeat (10) @(negedge clk);
    measure(40, d); chk("R3 gate open", d, 16'd10);
    ext_en = 1'b0;
    wr(2'd0, 16'h0009);
    repeat (10) @(negedge clk);
    measure(40, d); chk("R3 gate off pin ignored", d, 16'd10);
    wr(2'd0, 16'h0008);
    repeat (10) @(negedge clk);
    measure(40, d); chk("R3 run cleared", d, 16'd0);
    stop_all();
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_evt = 1'b0; repeat (6) @(negedge clk);
      ext_evt = 1'b1; repeat (6) @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic t_counter();
    logic [15:0] c0, c1;
    psc_sel = 2'b11;
    ext_evt = 1'b1;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h000B);
    repeat (10) @(negedge clk);
    rd(2'd1, c0); pulses(10); rd(2'd1, c1);
    chk("R4 edge count", c1 - c0, 16'd10);
    wr(2'd0, 16'h0009);
    rd(2'd1, c0); pulses(5); rd(2'd1, c1);
    chk("R4 pin ignored in timer use", c1 - c0, 16'd0);
    stop_all();
  endtask

  task automatic ovf_case(input logic [15:0] ctrl, input logic [15:0] start,
                          input logic [15:0] exp, input string req);
    logic [15:0] v;
    psc_sel = 2'b10;
    wr(2'd1, start);
    wr(2'd0, ctrl);
    wait_irq(1'b0, req);
    rd(2'd1, v); chk(req, v, exp);
    stop_all();
  endtask

  task automatic t_modes();
    logic [15:0] v;
    wr(2'd2, 16'h1234);
    rd(2'd2, v); chk("R5 reload reg", v, 16'h1234);
    ovf_case(16'h0001, 16'hFFFE, 16'h1234, "R5 reload");
    ovf_case(16'h0009, 16'hFFFE, 16'h0000, "R6 wrap");
    ovf_case(16'h0011, 16'hA0FE, 16'hA0A0, "R7 byte reload");
  endtask

  task automatic t_split();
    logic [15:0] v;
    psc_sel = 2'b10;
    wr(2'd1, 16'h55FE);
    wr(2'd0, 16'h0019);
    wait_irq(1'b0, "R8 low flag");
    rd(2'd1, v); chk("R8 low wrap", v, 16'h5500);
    chk("R8 high flag idle", {15'h0, irq_hi}, 16'h0);
    rd1(2'd1, v); chk("R11 no split holds", v, 16'h55FE);
    stop_all();
    wr(2'd1, 16'hFF10);
    wr(2'd0, 16'h0038);
    wait_irq(1'b1, "R8 high flag");
    rd(2'd1, v); chk("R8 high wrap", v, 16'h0010);
    chk("R8 low flag idle", {15'h0, irq_lo}, 16'h0);
    stop_all();
  endtask

  task automatic t_flags();
    logic [15:0] v;
    wr(2'd3, 16'h0003);
    @(negedge clk);
    chk("R9 write sets", {14'h0, irq_hi, irq_lo}, 16'h3);
    @(negedge clk); irq_ack = 2'b01; @(negedge clk); irq_ack = 2'b00;
    chk("R9 ack lo", {14'h0, irq_hi, irq_lo}, 16'h2);
    @(negedge clk); irq_ack = 2'b10; @(negedge clk); irq_ack = 2'b00;
    rd(2'd3, v); chk("R9 ack hi", v, 16'h0);
    wr(2'd3, 16'h0001);
    wr(2'd3, 16'h0000);
    chk("R9 write clears", {15'h0, irq_lo}, 16'h0);
    wr(2'd1, 16'hBEEF);
    rd(2'd1, v); chk("R10 count write", v, 16'hBEEF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_presc();
    t_gate();
    t_counter();
    t_modes();
    t_split();
    t_flags();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule